// File: doc/BRIEF.md
# Asynchronous Handshake Bus Interface

This block links a bus master and a small memory slave that run on unrelated clocks. Every transfer moves forward only when the other side answers, through a fully interlocked request/acknowledge handshake, so neither side assumes anything about how fast the other one is. A local client hands the master a read or write command. The master places the address, a direction flag and any write data on the link. It waits a programmable settling time, then raises a read or write strobe and follows the acknowledge line through its rise and fall.

The slave brings the strobes into its own clock domain through two-flop synchronizers. It waits a response latency that can be set at run time, then either stores the write word or drives the read word. It raises acknowledge only after its data has been steady for a cycle. It drops acknowledge, and clears its data, only once it sees the strobe low. The master synchronizes acknowledge in the same way. It holds the address for the whole exchange, reports busy while the exchange runs, and gives a one-cycle done pulse when acknowledge has returned low.

Top module: `ahs_link`

## Requirements
- R1: While reset is held and right after its release, busy, done and rd_data are all 0.
- R2: The master holds the address, the direction flag (1 = write) and the write data with both strobes low for at least SETTLE_CYC master cycles (default 2) before it raises a strobe.
- R3: For a read, the slave drives the read word for at least one slave cycle before it raises acknowledge, and keeps that word unchanged while acknowledge is high.
- R4: A read of an address returns the word most recently written there.
- R5: A write stores its word at the given address only, including the lowest (0) and highest (2**ADDR_W-1) addresses, and a later write to the same address replaces the word.
- R6: The master keeps the address and direction flag unchanged from the acceptance of a command until done. The slave lowers acknowledge only after it has seen both strobes low.
- R7: The read and write strobes are never high together, and reads and writes that alternate return correct data.
- R8: busy rises in the cycle after a command is accepted and stays high until done. done is a single-cycle pulse and is high only while busy is low.
- R9: A command presented while busy is high is ignored. It starts no second transfer and changes no memory word.
- R10: The slave waits slv_latency slave cycles before it responds. Transfers complete correctly with a latency of 0 and of 15, and a latency of 15 makes the transfer take longer.
- R11: rd_data keeps the word of the last completed read until another read completes, and a write does not change it.
- R12: A command presented in the cycle done is high is accepted at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk | input | 1 | Master clock |
| s_clk | input | 1 | Slave clock, unrelated to m_clk |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| cmd_valid | input | 1 | Command present; accepted when the master is idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_wdata | input | DATA_W | Word to write |
| slv_latency | input | LAT_W | Slave response latency in slave cycles |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| rd_data | output | DATA_W | Word returned by the last completed read |

## Verification
The bench goes after the edges of the handshake. It checks that a slave with zero latency and one with the maximum latency both return correct words. A design that skipped a handshake step would capture stale or cleared data in the fast case, and one that ignored the latency would finish the slow transfer early. A command pulsed in the middle of a transfer must leave memory untouched and start no extra transfer. A command presented in the done cycle must start at once, and a design that gated acceptance wrongly would hang or lose that command. Reads at both ends of the address range and a write sandwiched between two reads catch address slicing errors, and also catch a rd_data register that is reloaded on writes.

// File: rtl/ahs_pkg.sv
package ahs_pkg;
  typedef enum logic [1:0] {
    M_IDLE, M_SETUP, M_STROBE, M_RELEASE
  } mst_state_e;

  typedef enum logic [1:0] {
    S_IDLE, S_WAIT, S_DRIVE, S_ACK
  } slv_state_e;
endpackage

// File: rtl/ahs_rst_sync.sv
module ahs_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_out = hold_q;
endmodule

// File: rtl/ahs_sync.sv
module ahs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/ahs_master.sv
module ahs_master
  import ahs_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int SETTLE_CYC  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_status,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  mst_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              isw_q, isw_n;
  logic [DATA_W-1:0] wdat_q, wdat_n;
  logic              rd_q, rd_n, wr_q, wr_n;
  logic [DATA_W-1:0] rdat_q, rdat_n;
  logic              done_q, done_n;
  logic              ack_s;

  ahs_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_ack), .q(ack_s)
  );

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    addr_n  = addr_q;
    isw_n   = isw_q;
    wdat_n  = wdat_q;
    rd_n    = rd_q;
    wr_n    = wr_q;
    rdat_n  = rdat_q;
    done_n  = 1'b0;
    case (state_q)
      M_IDLE: if (cmd_valid && !ack_s) begin
        state_n = M_SETUP;
        cnt_n   = '0;
        addr_n  = cmd_addr;
        isw_n   = cmd_write;
        wdat_n  = cmd_write ? cmd_wdata : '0;
      end
      M_SETUP: if (cnt_q == CNT_LAST) begin
        state_n = M_STROBE;
        rd_n    = !isw_q;
        wr_n    = isw_q;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
      M_STROBE: if (ack_s) begin
        if (!isw_q) rdat_n = bus_rdata;
        rd_n    = 1'b0;
        wr_n    = 1'b0;
        state_n = M_RELEASE;
      end
      M_RELEASE: if (!ack_s) begin
        state_n = M_IDLE;
        done_n  = 1'b1;
      end
      default: state_n = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      isw_q   <= 1'b0;
      wdat_q  <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      rdat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      addr_q  <= addr_n;
      isw_q   <= isw_n;
      wdat_q  <= wdat_n;
      rd_q    <= rd_n;
      wr_q    <= wr_n;
      rdat_q  <= rdat_n;
      done_q  <= done_n;
    end
  end

  assign busy       = (state_q != M_IDLE);
  assign done       = done_q;
  assign rd_data    = rdat_q;
  assign bus_addr   = addr_q;
  assign bus_status = isw_q;
  assign bus_wdata  = wdat_q;
  assign bus_rd     = rd_q;
  assign bus_wr     = wr_q;
endmodule

// File: rtl/ahs_slave.sv
module ahs_slave
  import ahs_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int LAT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAT_W-1:0]  latency,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_status,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  slv_state_e        state_q, state_n;
  logic [LAT_W-1:0]  lat_q, lat_n;
  logic              opw_q, opw_n;
  logic              ack_q, ack_n;
  logic [DATA_W-1:0] dout_q, dout_n;
  logic              mem_we;
  logic              rd_s, wr_s;
  logic [DATA_W-1:0] mem [DEPTH];

  ahs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_strb_sync (
    .clk(clk), .rst_n(rst_n), .d({bus_rd, bus_wr}), .q({rd_s, wr_s})
  );

  always_comb begin
    state_n = state_q;
    lat_n   = lat_q;
    opw_n   = opw_q;
    ack_n   = ack_q;
    dout_n  = dout_q;
    mem_we  = 1'b0;
    case (state_q)
      S_IDLE: if (rd_s || wr_s) begin
        state_n = S_WAIT;
        lat_n   = latency;
        opw_n   = bus_status;
      end
      S_WAIT: if (lat_q == '0) begin
        state_n = S_DRIVE;
        if (opw_q) mem_we = 1'b1;
        else       dout_n = mem[bus_addr];
      end else begin
        lat_n = lat_q - 1'b1;
      end
      S_DRIVE: begin
        ack_n   = 1'b1;
        state_n = S_ACK;
      end
      S_ACK: if (!rd_s && !wr_s) begin
        ack_n   = 1'b0;
        dout_n  = '0;
        state_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      lat_q   <= '0;
      opw_q   <= 1'b0;
      ack_q   <= 1'b0;
      dout_q  <= '0;
    end else begin
      state_q <= state_n;
      lat_q   <= lat_n;
      opw_q   <= opw_n;
      ack_q   <= ack_n;
      dout_q  <= dout_n;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[bus_addr] <= bus_wdata;
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = dout_q;
endmodule

// File: rtl/ahs_link.sv
module ahs_link #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter int LAT_W       = 4,
  parameter int SETTLE_CYC  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              m_clk,
  input  logic              s_clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [LAT_W-1:0]  slv_latency,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  logic              m_rst_n, s_rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_status, bus_rd, bus_wr, bus_ack;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;

  ahs_rst_sync u_m_rst (.clk(m_clk), .rst_n_in(rst_n), .rst_n_out(m_rst_n));
  ahs_rst_sync u_s_rst (.clk(s_clk), .rst_n_in(rst_n), .rst_n_out(s_rst_n));

  ahs_master #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SETTLE_CYC(SETTLE_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_master (
    .clk(m_clk), .rst_n(m_rst_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_status(bus_status), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  ahs_slave #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LAT_W(LAT_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_slave (
    .clk(s_clk), .rst_n(s_rst_n), .latency(slv_latency),
    .bus_addr(bus_addr), .bus_status(bus_status), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/ahs_link_chk.sv
module ahs_link_chk #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter int SETTLE_CYC = 2
) (
  input logic              m_clk,
  input logic              s_clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_status,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_ack,
  input logic [DATA_W-1:0] bus_rdata
);
  logic [7:0] setup_cnt_q;

  always_ff @(posedge m_clk or negedge rst_n) begin
    if (!rst_n)                                 setup_cnt_q <= '0;
    else if (!busy)                             setup_cnt_q <= '0;
    else if (!bus_rd && !bus_wr && setup_cnt_q != 8'hFF) setup_cnt_q <= setup_cnt_q + 1'b1;
  end

  // R2
  settle_pause_chk: assert property (@(posedge m_clk) disable iff (!rst_n)
    ($rose(bus_rd) || $rose(bus_wr)) |-> (setup_cnt_q >= 8'(SETTLE_CYC)));

  // R3
  data_before_ack_chk: assert property (@(posedge s_clk) disable iff (!rst_n)
    bus_ack |-> $stable(bus_rdata));

  // R6
  addr_hold_chk: assert property (@(posedge m_clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(bus_addr) && $stable(bus_status)));

  // R6
  ack_release_chk: assert property (@(posedge s_clk) disable iff (!rst_n)
    $fell(bus_ack) |-> $past(!bus_rd && !bus_wr));

  // R7
  strobe_excl_chk: assert property (@(posedge m_clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R8
  done_pulse_chk: assert property (@(posedge m_clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge m_clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind ahs_link ahs_link_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .m_clk(m_clk), .s_clk(s_clk), .rst_n(rst_n),
  .busy(busy), .done(done),
  .bus_addr(bus_addr), .bus_status(bus_status),
  .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_ack(bus_ack), .bus_rdata(bus_rdata)
);

// File: tb/ahs_link_test.sv
`timescale 1ns/1ps
module ahs_link_test;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int LW = 4;
  localparam int SETTLE = 2;

  logic          m_clk = 1'b0;
  logic          s_clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid, cmd_write;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic [LW-1:0] slv_latency;
  logic          busy, done;
  logic [DW-1:0] rd_data;

  always #10   m_clk = ~m_clk;
  always #18.5 s_clk = ~s_clk;

  ahs_link #(.ADDR_W(AW), .DATA_W(DW), .LAT_W(LW), .SETTLE_CYC(SETTLE)) uut (
    .m_clk(m_clk), .s_clk(s_clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .slv_latency(slv_latency),
    .busy(busy), .done(done), .rd_data(rd_data)
  );

  typedef struct {
    bit            is_rd;
    logic [AW-1:0] addr;
    logic [DW-1:0] exp;
  } sb_item_t;

  sb_item_t      sb_q[$];
  logic [DW-1:0] model [1 << AW];
  int            n_chk = 0;
  int            n_bad = 0;
  bit            finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one scoreboard item per done pulse
  always @(negedge m_clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R9 done pulse with nothing outstanding", 1, 0);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (it.is_rd)
          check(rd_data == it.exp, "R4 R5 R7 read word", int'(rd_data), int'(it.exp));
      end
    end
  end

  task automatic start_cmd(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    sb_item_t it;
    it.is_rd = !wr;
    it.addr  = a;
    it.exp   = wr ? d : model[a];
    if (wr) model[a] = d;
    sb_q.push_back(it);
    cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
    @(negedge m_clk);
    cmd_valid = 1'b0;
    check(busy == 1'b1, "R8 R12 busy after accept", int'(busy), 1);
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done) begin
      @(negedge m_clk);
      cyc++;
    end
  endtask

  task automatic run_cmd(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output int cyc);
    start_cmd(wr, a, d);
    wait_done(cyc);
  endtask

  initial begin
    int cyc, fast_cyc, slow_cyc;
    bit busy_seen;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0;
    cmd_addr = '0; cmd_wdata = '0; slv_latency = 4'd1;
    repeat (4) @(negedge m_clk);
    check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge m_clk);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(rd_data == '0, "R1 rd_data after reset", int'(rd_data), 0);

    // R5 boundary addresses, R4 read back, R7 alternation
    run_cmd(1'b1, 4'd0,  16'hA5A5, cyc);
    run_cmd(1'b1, 4'd15, 16'h5A5A, cyc);
    run_cmd(1'b1, 4'd7,  16'h1234, cyc);
    run_cmd(1'b0, 4'd0,  '0, cyc);
    run_cmd(1'b0, 4'd15, '0, cyc);
    run_cmd(1'b1, 4'd8,  16'h0F0F, cyc);
    run_cmd(1'b0, 4'd7,  '0, cyc);
    run_cmd(1'b0, 4'd8,  '0, cyc);
    // R12 back-to-back write then read, issued in the done cycle
    run_cmd(1'b1, 4'd9,  16'hBEEF, cyc);
    run_cmd(1'b0, 4'd9,  '0, cyc);

    // R11 write leaves rd_data alone
    run_cmd(1'b0, 4'd7, '0, cyc);
    run_cmd(1'b1, 4'd2, 16'h0000, cyc);
    check(rd_data == 16'h1234, "R11 rd_data after write", int'(rd_data), 16'h1234);

    // R9 command during busy is ignored
    start_cmd(1'b1, 4'd3, 16'h1111);
    repeat (2) @(negedge m_clk);
    check(busy == 1'b1, "R9 still busy", int'(busy), 1);
    cmd_write = 1'b1; cmd_addr = 4'd3; cmd_wdata = 16'hDEAD; cmd_valid = 1'b1;
    @(negedge m_clk);
    cmd_valid = 1'b0;
    wait_done(cyc);
    busy_seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge m_clk);
      if (busy) busy_seen = 1'b1;
    end
    check(!busy_seen, "R9 no extra transfer", int'(busy_seen), 0);
    run_cmd(1'b0, 4'd3, '0, cyc);

    // R10 latency 0 and 15; R3 fast slave; R6 slow slave
    slv_latency = 4'd0;
    run_cmd(1'b1, 4'd12, 16'hC0DE, cyc);
    run_cmd(1'b0, 4'd12, '0, fast_cyc);
    check(rd_data == 16'hC0DE, "R3 R10 fast slave read", int'(rd_data), 16'hC0DE);
    check(fast_cyc >= SETTLE + 4, "R2 settle plus handshake cycles", fast_cyc, SETTLE + 4);
    slv_latency = 4'd15;
    run_cmd(1'b1, 4'd13, 16'h7E57, cyc);
    run_cmd(1'b0, 4'd13, '0, slow_cyc);
    check(rd_data == 16'h7E57, "R6 R10 slow slave read", int'(rd_data), 16'h7E57);
    check(slow_cyc >= fast_cyc + 20, "R10 latency lengthens transfer", slow_cyc, fast_cyc + 20);

    // R5 overwrite
    slv_latency = 4'd2;
    run_cmd(1'b1, 4'd7, 16'hFFFF, cyc);
    run_cmd(1'b0, 4'd7, '0, cyc);
    run_cmd(1'b0, 4'd0, '0, cyc);

    repeat (4) @(negedge m_clk);
    check(sb_q.size() == 0, "R8 every command completed", sb_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge m_clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule